// File: doc/BRIEF.md
# Sector-Buffered Transfer Engine

This block sits between a processor-facing byte data register and a storage target that works in 512-byte sectors. A single sector buffer is shared by both transfer directions. A signed count of remaining bytes, loaded when a transfer starts, decides when the buffer is exchanged with the device side and when the transfer is finished.

In the outbound direction, each accepted processor write goes into the buffer at a running pointer. The write that fills the last slot hands the whole sector to the device side, rewinds the pointer and reduces the remaining count by one sector. When that count is used up, the block raises the end-of-transfer status code. In the inbound direction, a transfer start requests the first sector, or less for a short transfer. Each accepted processor read returns the byte at the pointer. Reading past a full sector asks for the next one. When the remaining data is shorter than a sector, the pointer stops on the last valid byte.

The device side streams bytes with a valid/ready pair in index order. While a stream is running, the processor side is locked out.

Top module: `sector_mover`

## Requirements
- R1: After reset, req_o, busy_o, dev_flush_o, dev_fill_o, status_o and cpu_rdata_o are all zero.
- R2: A write is stored only when phase_i equals 3'd0 (data-out) and icmd_i equals 8'h01. It lands at the pointer, which then moves up by one. Writes under any other phase_i or icmd_i value have no effect.
- R3: A stored write at index 511 starts a flush with dev_len_o = 512. The pointer returns to 0 and the remaining count drops by 512.
- R4: If the remaining count is zero or negative after the drop in R3, status_o becomes 8'hC8 and keeps that value until reset.
- R5: A read is accepted only when phase_i equals 3'd1 (data-in). The byte at the pointer appears on cpu_rdata_o one cycle after the read. A read in any other phase leaves cpu_rdata_o and the pointer unchanged.
- R6: While the remaining count is below 512, a read moves the pointer up only if it is below count-1. Otherwise the pointer holds, so further reads repeat the last valid byte.
- R7: While the remaining count is 512 or more, a read at index 511 wraps the pointer to 0 and drops the count by 512. A fill of min(count, 512) bytes is requested only if the new count is still positive.
- R8: A start with xfer_dir_in_i = 1 and a positive limit clears buffer byte [limit] when the limit is below 512 and requests a fill of min(limit, 512) bytes. req_o rises when that fill completes. Every accepted start clears req_o.
- R9: While busy_o is high, and in the cycle of an accepted start, processor reads and writes are ignored. A start is ignored while busy_o is high.
- R10: A flush presents buffer bytes in index order on dev_out_data_o and moves one per cycle with dev_out_ready_i high. A fill stores dev_in_data_i in index order on each cycle with dev_in_valid_i high. dev_flush_o and dev_fill_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 3 | Current bus phase code |
| icmd_i | input | 8 | Initiator command value |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_rdata_o | output | 8 | Byte returned by the last accepted read |
| xfer_start_i | input | 1 | Start pulse: loads the limit and rewinds the pointer |
| xfer_dir_in_i | input | 1 | Direction of the started transfer, 1 = inbound |
| xfer_limit_i | input | LIM_W | Signed byte count of the started transfer |
| busy_o | output | 1 | Device-side stream in progress |
| req_o | output | 1 | First inbound sector is ready |
| status_o | output | 8 | Transfer status, 8'hC8 when outbound data is used up |
| dev_flush_o | output | 1 | Flush active; acts as out-valid |
| dev_fill_o | output | 1 | Fill active; acts as in-ready |
| dev_len_o | output | LEN_W | Byte count of the current stream |
| dev_out_data_o | output | 8 | Outbound byte at the stream index |
| dev_out_ready_i | input | 1 | Device takes the outbound byte |
| dev_in_valid_i | input | 1 | Device offers an inbound byte |
| dev_in_data_i | input | 8 | Inbound byte |

## Verification
The sector-boundary wrap on the inbound side is the hardest case to reach. It needs a limit above one sector and then exactly 512 accepted reads before the shorter refill, and the stalled pointer, can be seen. The bench loads a 600-byte limit, supplies a full first sector and reads all of it. Part way through, it inserts a wrong-phase read and a read while busy. It then checks that the second request carries 88 bytes and that reading past the end repeats the final byte. The cleared pad byte can never be read, so a bound property covers it, and the bench confirms the request length that goes with it.

// File: rtl/sm_pkg.sv
package sm_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_FILL  = 2'd2
    } dev_op_e;

    localparam logic [2:0] PH_DOUT      = 3'd0;
    localparam logic [2:0] PH_DIN       = 3'd1;
    localparam logic [7:0] ICMD_DATA    = 8'h01;
    localparam logic [7:0] STAT_DMA_END = 8'hC8;
endpackage

// File: rtl/sm_buf.sv
module sm_buf #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/sm_stream.sv
module sm_stream
    import sm_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             flush_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             out_ready_i,
    input  logic             in_valid_i,
    output logic             flush_o,
    output logic             fill_o,
    output logic [LEN_W-1:0] len_o,
    output logic [PTR_W-1:0] idx_o,
    output logic             step_o,
    output logic             done_o
);
    typedef struct packed {
        dev_op_e          op;
        logic [PTR_W-1:0] idx;
        logic [LEN_W-1:0] len;
    } strm_t;

    strm_t st_d, st_q;
    logic  last;

    always_comb begin
        st_d   = st_q;
        step_o = ((st_q.op == OP_FLUSH) && out_ready_i) ||
                 ((st_q.op == OP_FILL) && in_valid_i);
        last   = (LEN_W'(st_q.idx) == (st_q.len - 1'b1));
        done_o = step_o && last;
        if (go_i) begin
            st_d.op  = flush_i ? OP_FLUSH : OP_FILL;
            st_d.idx = '0;
            st_d.len = len_i;
        end else if (step_o) begin
            if (last) st_d.op = OP_IDLE;
            else      st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{op: OP_IDLE, idx: '0, len: '0};
        else        st_q <= st_d;
    end

    assign flush_o = (st_q.op == OP_FLUSH);
    assign fill_o  = (st_q.op == OP_FILL);
    assign len_o   = st_q.len;
    assign idx_o   = st_q.idx;
endmodule

// File: rtl/sector_mover.sv
module sector_mover
    import sm_pkg::*;
#(
    parameter int SECT  = 512,
    parameter int DW    = 8,
    parameter int LIM_W = 16,
    localparam int PTR_W = $clog2(SECT),
    localparam int LEN_W = $clog2(SECT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       phase_i,
    input  logic [7:0]       icmd_i,
    input  logic             cpu_wr_i,
    input  logic [DW-1:0]    cpu_wdata_i,
    input  logic             cpu_rd_i,
    output logic [DW-1:0]    cpu_rdata_o,
    input  logic             xfer_start_i,
    input  logic             xfer_dir_in_i,
    input  logic [LIM_W-1:0] xfer_limit_i,
    output logic             busy_o,
    output logic             req_o,
    output logic [7:0]       status_o,
    output logic             dev_flush_o,
    output logic             dev_fill_o,
    output logic [LEN_W-1:0] dev_len_o,
    output logic [DW-1:0]    dev_out_data_o,
    input  logic             dev_out_ready_i,
    input  logic             dev_in_valid_i,
    input  logic [DW-1:0]    dev_in_data_i
);
    localparam logic [PTR_W-1:0]        LAST_IDX = PTR_W'(SECT - 1);
    localparam logic signed [LIM_W-1:0] SECT_S   = LIM_W'(SECT);
    localparam logic signed [LIM_W-1:0] ZERO_S   = '0;
    localparam logic signed [LIM_W-1:0] ONE_S    = LIM_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [LIM_W-1:0] limit;
        logic [DW-1:0]    rdata;
        logic [7:0]       status;
        logic             req;
        logic             req_pend;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             go, go_flush;
    logic [LEN_W-1:0] go_len;
    logic             ctl_we;
    logic [PTR_W-1:0] ctl_waddr;
    logic [DW-1:0]    ctl_wdata;
    logic             buf_we;
    logic [PTR_W-1:0] buf_waddr;
    logic [DW-1:0]    buf_wdata;
    logic [DW-1:0]    cpu_byte;
    logic [PTR_W-1:0] s_idx;
    logic             s_step, s_done;
    logic             wr_ok, rd_ok;
    logic signed [LIM_W-1:0] lim_q, lim_new, lim_in, ptr_ext;

    function automatic logic [LEN_W-1:0] clip_len(input logic signed [LIM_W-1:0] v);
        return (v < SECT_S) ? LEN_W'(v) : LEN_W'(SECT);
    endfunction

    always_comb begin
        st_d      = st_q;
        go        = 1'b0;
        go_flush  = 1'b0;
        go_len    = '0;
        ctl_we    = 1'b0;
        ctl_waddr = st_q.ptr;
        ctl_wdata = cpu_wdata_i;
        lim_q     = $signed(st_q.limit);
        lim_in    = $signed(xfer_limit_i);
        lim_new   = lim_q - SECT_S;
        ptr_ext   = $signed({{(LIM_W - PTR_W){1'b0}}, st_q.ptr});
        wr_ok     = cpu_wr_i && !busy_o && !xfer_start_i &&
                    (phase_i == PH_DOUT) && (icmd_i == ICMD_DATA);
        rd_ok     = cpu_rd_i && !busy_o && !xfer_start_i && (phase_i == PH_DIN);

        if (s_done && st_q.req_pend) begin
            st_d.req      = 1'b1;
            st_d.req_pend = 1'b0;
        end

        if (xfer_start_i && !busy_o) begin
            st_d.limit    = xfer_limit_i;
            st_d.ptr      = '0;
            st_d.req      = 1'b0;
            st_d.req_pend = 1'b0;
            if (xfer_dir_in_i && (lim_in > ZERO_S)) begin
                go            = 1'b1;
                go_len        = clip_len(lim_in);
                st_d.req_pend = 1'b1;
                if (lim_in < SECT_S) begin
                    ctl_we    = 1'b1;
                    ctl_waddr = PTR_W'(xfer_limit_i);
                    ctl_wdata = '0;
                end
            end
        end else if (wr_ok) begin
            ctl_we = 1'b1;
            if (st_q.ptr == LAST_IDX) begin
                go         = 1'b1;
                go_flush   = 1'b1;
                go_len     = LEN_W'(SECT);
                st_d.ptr   = '0;
                st_d.limit = lim_new;
                if (lim_new <= ZERO_S) st_d.status = STAT_DMA_END;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end else if (rd_ok) begin
            st_d.rdata = cpu_byte;
            if (lim_q < SECT_S) begin
                if (ptr_ext < (lim_q - ONE_S)) st_d.ptr = st_q.ptr + 1'b1;
            end else if (st_q.ptr != LAST_IDX) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end else begin
                st_d.ptr   = '0;
                st_d.limit = lim_new;
                if (lim_new > ZERO_S) begin
                    go     = 1'b1;
                    go_len = clip_len(lim_new);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_we    = ctl_we || (s_step && dev_fill_o);
    assign buf_waddr = ctl_we ? ctl_waddr : s_idx;
    assign buf_wdata = ctl_we ? ctl_wdata : dev_in_data_i;

    sm_buf #(.DEPTH(SECT), .DW(DW), .AW(PTR_W)) buf_i (
        .clk       (clk),
        .we_i      (buf_we),
        .waddr_i   (buf_waddr),
        .wdata_i   (buf_wdata),
        .raddr_a_i (st_q.ptr),
        .rdata_a_o (cpu_byte),
        .raddr_b_i (s_idx),
        .rdata_b_o (dev_out_data_o)
    );

    sm_stream #(.PTR_W(PTR_W), .LEN_W(LEN_W)) strm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .flush_i     (go_flush),
        .len_i       (go_len),
        .out_ready_i (dev_out_ready_i),
        .in_valid_i  (dev_in_valid_i),
        .flush_o     (dev_flush_o),
        .fill_o      (dev_fill_o),
        .len_o       (dev_len_o),
        .idx_o       (s_idx),
        .step_o      (s_step),
        .done_o      (s_done)
    );

    assign busy_o      = dev_flush_o || dev_fill_o;
    assign req_o       = st_q.req;
    assign status_o    = st_q.status;
    assign cpu_rdata_o = st_q.rdata;
endmodule

// File: rtl/sm_chk.sv
module sm_chk #(
    parameter int SECT  = 512,
    parameter int DW    = 8,
    parameter int LIM_W = 16,
    parameter int PTR_W = 9,
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             start,
    input logic             dir_in,
    input logic [LIM_W-1:0] limit_in,
    input logic [2:0]       phase,
    input logic             cpu_rd,
    input logic [PTR_W-1:0] ptr,
    input logic [LIM_W-1:0] limit,
    input logic             buf_we,
    input logic [PTR_W-1:0] buf_waddr,
    input logic [DW-1:0]    buf_wdata,
    input logic             flush,
    input logic             fill,
    input logic [LEN_W-1:0] len,
    input logic             req,
    input logic [7:0]       status
);
    logic signed [LIM_W-1:0] lim_s, lin_s, ptr_s;
    logic rd_acc;
    assign lim_s  = $signed(limit);
    assign lin_s  = $signed(limit_in);
    assign ptr_s  = $signed({{(LIM_W - PTR_W){1'b0}}, ptr});
    assign rd_acc = cpu_rd && !busy && !start && (phase == 3'd1);

    a_r3_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush) |-> (len == LEN_W'(SECT)));

    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (lim_s < LIM_W'(SECT)) && (ptr_s == lim_s - LIM_W'(1))) |=> $stable(ptr));

    a_r8_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && dir_in && (lin_s > 0) && (lin_s < LIM_W'(SECT)))
        |-> (buf_we && (buf_waddr == PTR_W'(limit_in)) && (buf_wdata == '0)));

    a_r8_req_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(fill));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && fill));

    a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'hC8) |=> (status == 8'hC8));

    a_r4_status_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h00) || (status == 8'hC8));
endmodule

bind sector_mover sm_chk #(
    .SECT(SECT), .DW(DW), .LIM_W(LIM_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_o),
    .start     (xfer_start_i),
    .dir_in    (xfer_dir_in_i),
    .limit_in  (xfer_limit_i),
    .phase     (phase_i),
    .cpu_rd    (cpu_rd_i),
    .ptr       (st_q.ptr),
    .limit     (st_q.limit),
    .buf_we    (buf_we),
    .buf_waddr (buf_waddr),
    .buf_wdata (buf_wdata),
    .flush     (dev_flush_o),
    .fill      (dev_fill_o),
    .len       (dev_len_o),
    .req       (req_o),
    .status    (status_o)
);

// File: tb/sector_mover_tb_top.sv
module sector_mover_tb_top;
    localparam int LIM_W = 16;
    localparam int LEN_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       phase = 3'd0;
    logic [7:0]       icmd = 8'h01;
    logic             wr = 1'b0, rd = 1'b0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             start = 1'b0, dir_in = 1'b0;
    logic [LIM_W-1:0] limit = '0;
    logic             busy, req;
    logic [7:0]       status;
    logic             flush, fill;
    logic [LEN_W-1:0] dlen;
    logic [7:0]       out_data;
    logic             out_ready = 1'b0, in_valid = 1'b0;
    logic [7:0]       in_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sector_mover dut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .icmd_i(icmd),
        .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rd_i(rd), .cpu_rdata_o(rdata),
        .xfer_start_i(start), .xfer_dir_in_i(dir_in), .xfer_limit_i(limit),
        .busy_o(busy), .req_o(req), .status_o(status),
        .dev_flush_o(flush), .dev_fill_o(fill), .dev_len_o(dlen),
        .dev_out_data_o(out_data), .dev_out_ready_i(out_ready),
        .dev_in_valid_i(in_valid), .dev_in_data_i(in_data)
    );

    function automatic logic [7:0] pat(int s, int i);
        return 8'(i * 7 + s * 29 + 3);
    endfunction

    task automatic chk(bit ok, string req_tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic cpu_write(logic [7:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic cpu_read(output logic [7:0] v);
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic do_start(bit din, int lim);
        @(negedge clk); start = 1'b1; dir_in = din; limit = LIM_W'(lim);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic write_sector(int s);
        for (int i = 0; i < 512; i++) cpu_write(pat(s, i));
    endtask

    task automatic collect_flush(int s, int n, string tag);
        int bad = 0;
        logic [7:0] first_bad = '0;
        for (int i = 0; i < n; i++) begin
            out_ready = 1'b1;
            if (!flush || out_data != pat(s, i)) begin
                if (bad == 0) first_bad = out_data;
                bad++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(bad == 0, tag, int'(first_bad), int'(pat(s, 0)));
        chk(!flush && !busy, "R10 flush ends after len bytes", int'(flush), 0);
    endtask

    task automatic fill_bytes(int s, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); in_valid = 1'b1; in_data = pat(s, i);
        end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic read_span(int s, int from, int n, string tag);
        int bad = 0;
        logic [7:0] v, got = '0, want = '0;
        for (int i = from; i < from + n; i++) begin
            cpu_read(v);
            if (v != pat(s, i) && bad == 0) begin got = v; want = pat(s, i); end
            if (v != pat(s, i)) bad++;
        end
        chk(bad == 0, tag, int'(got), int'(want));
    endtask

    task automatic t_reset;
        chk(req == 1'b0 && busy == 1'b0, "R1 req/busy", {req, busy}, 0);
        chk(flush == 1'b0 && fill == 1'b0, "R1 flush/fill", {flush, fill}, 0);
        chk(status == 8'h00 && rdata == 8'h00, "R1 status/rdata", {status, rdata}, 0);
    endtask

    task automatic t_data_out;
        phase = 3'd0; icmd = 8'h01;
        do_start(1'b0, 1024);
        chk(!busy, "R8 outbound start requests nothing", int'(busy), 0);
        icmd = 8'h00; cpu_write(8'h55);
        icmd = 8'h01;
        write_sector(0);
        chk(flush && dlen == 10'd512, "R3 flush of 512 starts", int'(dlen), 512);
        chk(status == 8'h00, "R4 no end status with 512 left", int'(status), 0);
        cpu_write(8'hEE);
        collect_flush(0, 512, "R2 R3 R10 sector 0 flush data");
        phase = 3'd1; cpu_write(8'h77);
        phase = 3'd0;
        write_sector(1);
        chk(status == 8'hC8, "R4 end status after last sector", int'(status), 'hC8);
        collect_flush(1, 512, "R9 R2 sector 1 flush after ignored writes");
        chk(status == 8'hC8, "R4 status held", int'(status), 'hC8);
    endtask

    task automatic t_in_short;
        logic [7:0] v;
        phase = 3'd1;
        do_start(1'b1, 5);
        chk(fill && dlen == 10'd5, "R8 short fill length", int'(dlen), 5);
        chk(!req, "R8 req low before fill", int'(req), 0);
        fill_bytes(2, 5);
        chk(req, "R8 req after fill", int'(req), 1);
        read_span(2, 0, 5, "R5 short read data");
        cpu_read(v);
        chk(v == pat(2, 4), "R6 stall repeats last byte", int'(v), int'(pat(2, 4)));
        cpu_read(v);
        chk(v == pat(2, 4), "R6 stall holds", int'(v), int'(pat(2, 4)));
    endtask

    task automatic t_in_long;
        logic [7:0] v;
        phase = 3'd1;
        do_start(1'b1, 600);
        chk(!req, "R8 start clears req", int'(req), 0);
        chk(fill && dlen == 10'd512, "R8 first fill clipped to 512", int'(dlen), 512);
        cpu_read(v);
        chk(v == pat(2, 4), "R9 read ignored while busy", int'(v), int'(pat(2, 4)));
        fill_bytes(3, 512);
        read_span(3, 0, 300, "R9 R5 first part after busy read");
        phase = 3'd0; cpu_read(v);
        chk(v == pat(3, 299), "R5 wrong-phase read ignored", int'(v), int'(pat(3, 299)));
        phase = 3'd1;
        read_span(3, 300, 212, "R5 rest of sector");
        chk(fill && dlen == 10'd88, "R7 refill of remaining 88", int'(dlen), 88);
        chk(req, "R8 req kept over refill", int'(req), 1);
        fill_bytes(4, 88);
        read_span(4, 0, 88, "R7 second sector data");
        cpu_read(v);
        chk(v == pat(4, 87), "R6 stall after wrap", int'(v), int'(pat(4, 87)));
    endtask

    task automatic t_in_exact;
        phase = 3'd1;
        do_start(1'b1, 512);
        fill_bytes(5, 512);
        read_span(5, 0, 512, "R7 exact sector read");
        @(negedge clk);
        chk(!fill && !busy, "R7 no refill when count reaches zero", int'(fill), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_out();
        t_in_short();
        t_in_long();
        t_in_exact();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule